// File: doc/BRIEF.md
# Pipeline Hazard Control Unit

This block steers a five-stage in-order integer pipeline: fetch, decode, execute, memory access and write-back. Each cycle it receives the decode-stage instruction's register fields, write flag and memory flags, together with the branch outcome. It keeps its own shadow of the execute, memory and write-back slots, and from this it produces the pipeline's control signals. These are a PC hold, a decode-register hold, no-op insertion into the decode and execute registers, ALU operand bypass selects, and a fetch redirect with its target.

All three hazard classes are handled. A single memory port serves both instruction fetch and data access, so fetch gives way whenever the memory-stage instruction uses that port. Register dependences are resolved either by bypassing or, when bypassing is compiled out, by holding the consumer until its producer has written back. Branches are assumed not taken. A taken branch discards the younger wrong-path instructions and restarts fetch at the target. A parameter chooses whether branches resolve in decode or in execute.

Top module: `hazard_ctrl`

## Requirements
- R1: While reset is asserted and after its release with no instruction and no branch present, every hold, no-op and redirect output is 0 and both operand selects are 0.
- R2: When the instruction in the memory stage accesses memory, `hold_pc` is 1 and, unless a data stall holds decode, `bubble_id` is 1.
- R3: Operand selects use 0 = register file, 1 = result of the instruction now in the memory stage, 2 = result of the instruction now in write-back. When both of those instructions write the operand's register, 1 wins.
- R4: A read or write of register 0 never produces a nonzero select and never causes a data stall.
- R5: With bypassing (FWD_EN=1), a consumer directly behind a load is held in decode for exactly 1 cycle. A consumer directly behind a non-load producer is not held.
- R6: With bypassing off (FWD_EN=0), a consumer is held in decode until its producer has left write-back. This is 3, 2 or 1 cycles when 0, 1 or 2 slots separate them. Both selects stay 0.
- R7: During a data stall, `hold_pc`, `hold_id` and `bubble_ex` are all 1.
- R8: A branch that resolves not taken causes no redirect and no no-op insertion.
- R9: A taken branch drives `redirect`=1 and `redirect_pc`=target, and `bubble_id`=1. With RESOLVE_IN_ID=0, `bubble_ex` is also 1 (2 lost slots). With RESOLVE_IN_ID=1, `bubble_ex` stays 0 (1 lost slot).
- R10: In a cycle with a taken branch, `hold_pc` and `hold_id` are 0, even when a data or fetch-port conflict is present.
- R11: A squashed slot carries no register write and no memory access. A wrong-path load causes no later stall and no later fetch conflict.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| id_valid | input | 1 | Decode stage holds a real instruction |
| id_rs1 | input | REG_AW | First source register |
| id_rs1_en | input | 1 | First source is read |
| id_rs2 | input | REG_AW | Second source register |
| id_rs2_en | input | 1 | Second source is read |
| id_rd | input | REG_AW | Destination register |
| id_wen | input | 1 | Instruction writes its destination |
| id_load | input | 1 | Instruction is a load |
| id_mem | input | 1 | Instruction uses the memory port (load or store) |
| br_valid | input | 1 | A branch is resolving this cycle |
| br_taken | input | 1 | Resolved branch is taken |
| br_target | input | PC_W | Resolved branch target |
| hold_pc | output | 1 | Keep the PC (no new fetch) |
| hold_id | output | 1 | Keep the decode register |
| bubble_id | output | 1 | Load a no-op into the decode register |
| bubble_ex | output | 1 | Load a no-op into the execute register |
| fwd_a | output | 2 | Select for ALU operand A |
| fwd_b | output | 2 | Select for ALU operand B |
| redirect | output | 1 | Restart fetch at `redirect_pc` |
| redirect_pc | output | PC_W | Redirect target |

## Verification
The bench builds two copies of the block side by side. The first has bypassing on and branches resolving in execute. The second has bypassing off and branches resolving in decode. The same producer–gap–consumer streams run through both, so stall lengths and select values can be compared for the two dependence policies. The same arrangement exposes both branch penalties, and the way a fetch-port conflict inserts slack that shortens a later data stall.

// File: rtl/hz_pkg.sv
package hz_pkg;

  // Source chosen for an ALU operand in the execute stage.
  typedef enum logic [1:0] {
    FWD_RF = 2'd0,   // register file value
    FWD_MA = 2'd1,   // result held by the memory-stage instruction
    FWD_WB = 2'd2    // result held by the write-back instruction
  } fwd_src_e;

  localparam int unsigned NUM_OPERANDS = 2;

endpackage

// File: rtl/hz_track.sv
// Shadow copy of the execute, memory and write-back slots: only the fields
// the hazard logic needs, advanced one stage per cycle.
module hz_track #(
  parameter int unsigned RAW = 5
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           id_valid,
  input  logic [RAW-1:0] id_rd,
  input  logic [RAW-1:0] id_rs1,
  input  logic           id_rs1_en,
  input  logic [RAW-1:0] id_rs2,
  input  logic           id_rs2_en,
  input  logic           id_wen,
  input  logic           id_load,
  input  logic           id_mem,
  input  logic           kill_ex,
  output logic           ex_vld,
  output logic           ex_wen,
  output logic [RAW-1:0] ex_rd,
  output logic           ex_load,
  output logic [RAW-1:0] ex_rs1,
  output logic           ex_rs1_en,
  output logic [RAW-1:0] ex_rs2,
  output logic           ex_rs2_en,
  output logic           ma_vld,
  output logic           ma_wen,
  output logic [RAW-1:0] ma_rd,
  output logic           ma_mem,
  output logic           wb_vld,
  output logic           wb_wen,
  output logic [RAW-1:0] wb_rd
);

  localparam int unsigned NSTG = 3;  // EX, MA, WB

  logic enter_ok;
  assign enter_ok = id_valid & ~kill_ex;

  // Destination bookkeeping repeats for every tracked stage.
  for (genvar k = 0; k < NSTG; k++) begin : g_stg
    logic           vld_r;
    logic           wen_r;
    logic [RAW-1:0] rd_r;
    if (k == 0) begin : g_head
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          vld_r <= 1'b0;
          wen_r <= 1'b0;
          rd_r  <= '0;
        end else begin
          vld_r <= enter_ok;
          wen_r <= enter_ok & id_wen;
          rd_r  <= enter_ok ? id_rd : '0;
        end
      end
    end else begin : g_tail
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          vld_r <= 1'b0;
          wen_r <= 1'b0;
          rd_r  <= '0;
        end else begin
          vld_r <= g_stg[k-1].vld_r;
          wen_r <= g_stg[k-1].wen_r;
          rd_r  <= g_stg[k-1].rd_r;
        end
      end
    end
  end

  // Execute-only and memory-only extras.
  logic           ex_load_q, ex_mem_q, ma_mem_q;
  logic [RAW-1:0] ex_rs1_q, ex_rs2_q;
  logic           ex_rs1_en_q, ex_rs2_en_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ex_load_q   <= 1'b0;
      ex_mem_q    <= 1'b0;
      ma_mem_q    <= 1'b0;
      ex_rs1_q    <= '0;
      ex_rs2_q    <= '0;
      ex_rs1_en_q <= 1'b0;
      ex_rs2_en_q <= 1'b0;
    end else begin
      ex_load_q   <= enter_ok & id_load;
      ex_mem_q    <= enter_ok & id_mem;
      ma_mem_q    <= ex_mem_q;
      ex_rs1_q    <= enter_ok ? id_rs1 : '0;
      ex_rs2_q    <= enter_ok ? id_rs2 : '0;
      ex_rs1_en_q <= enter_ok & id_rs1_en;
      ex_rs2_en_q <= enter_ok & id_rs2_en;
    end
  end

  assign ex_vld    = g_stg[0].vld_r;
  assign ex_wen    = g_stg[0].wen_r;
  assign ex_rd     = g_stg[0].rd_r;
  assign ma_vld    = g_stg[1].vld_r;
  assign ma_wen    = g_stg[1].wen_r;
  assign ma_rd     = g_stg[1].rd_r;
  assign wb_vld    = g_stg[2].vld_r;
  assign wb_wen    = g_stg[2].wen_r;
  assign wb_rd     = g_stg[2].rd_r;
  assign ex_load   = ex_load_q;
  assign ex_rs1    = ex_rs1_q;
  assign ex_rs2    = ex_rs2_q;
  assign ex_rs1_en = ex_rs1_en_q;
  assign ex_rs2_en = ex_rs2_en_q;
  assign ma_mem    = ma_mem_q;

endmodule

// File: rtl/hz_dep.sv
// Decode-stage dependence check against the older in-flight instructions.
module hz_dep #(
  parameter int unsigned RAW    = 5,
  parameter bit          FWD_EN = 1'b1
) (
  input  logic           id_valid,
  input  logic [RAW-1:0] id_rs1,
  input  logic           id_rs1_en,
  input  logic [RAW-1:0] id_rs2,
  input  logic           id_rs2_en,
  input  logic           ex_vld,
  input  logic           ex_wen,
  input  logic [RAW-1:0] ex_rd,
  input  logic           ex_load,
  input  logic           ma_vld,
  input  logic           ma_wen,
  input  logic [RAW-1:0] ma_rd,
  input  logic           wb_vld,
  input  logic           wb_wen,
  input  logic [RAW-1:0] wb_rd,
  output logic           load_use,
  output logic           raw_pending,
  output logic           data_stall
);

  // A producer matters only if it really writes a nonzero register that is read.
  function automatic logic writes_src(input logic vld, input logic wen,
                                      input logic [RAW-1:0] rd,
                                      input logic [RAW-1:0] rs, input logic rs_en);
    return vld & wen & rs_en & (rd != '0) & (rd == rs);
  endfunction

  logic hit_ex, hit_ma, hit_wb;

  assign hit_ex = writes_src(ex_vld, ex_wen, ex_rd, id_rs1, id_rs1_en)
                | writes_src(ex_vld, ex_wen, ex_rd, id_rs2, id_rs2_en);
  assign hit_ma = writes_src(ma_vld, ma_wen, ma_rd, id_rs1, id_rs1_en)
                | writes_src(ma_vld, ma_wen, ma_rd, id_rs2, id_rs2_en);
  assign hit_wb = writes_src(wb_vld, wb_wen, wb_rd, id_rs1, id_rs1_en)
                | writes_src(wb_vld, wb_wen, wb_rd, id_rs2, id_rs2_en);

  assign load_use    = hit_ex & ex_load;
  assign raw_pending = hit_ex | hit_ma | hit_wb;

  if (FWD_EN) begin : g_byp
    assign data_stall = id_valid & load_use;
  end else begin : g_nobyp
    assign data_stall = id_valid & raw_pending;
  end

endmodule

// File: rtl/hz_fwd.sv
// Operand bypass selection for the instruction in the execute stage.
module hz_fwd
  import hz_pkg::*;
#(
  parameter int unsigned RAW    = 5,
  parameter bit          FWD_EN = 1'b1
) (
  input  logic           ex_vld,
  input  logic [RAW-1:0] ex_rs1,
  input  logic           ex_rs1_en,
  input  logic [RAW-1:0] ex_rs2,
  input  logic           ex_rs2_en,
  input  logic           ma_vld,
  input  logic           ma_wen,
  input  logic [RAW-1:0] ma_rd,
  input  logic           wb_vld,
  input  logic           wb_wen,
  input  logic [RAW-1:0] wb_rd,
  output fwd_src_e       sel_a,
  output fwd_src_e       sel_b
);

  function automatic fwd_src_e pick(input logic use_it, input logic [RAW-1:0] rs,
                                    input logic mv, input logic mw, input logic [RAW-1:0] mrd,
                                    input logic wv, input logic ww, input logic [RAW-1:0] wrd);
    fwd_src_e s;
    s = FWD_RF;
    if (use_it && rs != '0) begin
      if (mv && mw && mrd == rs)      s = FWD_MA;  // youngest producer first
      else if (wv && ww && wrd == rs) s = FWD_WB;
    end
    return s;
  endfunction

  logic [RAW-1:0] op_rs [NUM_OPERANDS];
  logic           op_en [NUM_OPERANDS];
  fwd_src_e       op_sel[NUM_OPERANDS];

  assign op_rs[0] = ex_rs1;
  assign op_rs[1] = ex_rs2;
  assign op_en[0] = ex_rs1_en;
  assign op_en[1] = ex_rs2_en;

  for (genvar op = 0; op < NUM_OPERANDS; op++) begin : g_op
    if (FWD_EN) begin : g_on
      assign op_sel[op] = pick(ex_vld & op_en[op], op_rs[op],
                               ma_vld, ma_wen, ma_rd, wb_vld, wb_wen, wb_rd);
    end else begin : g_off
      assign op_sel[op] = FWD_RF;
    end
  end

  assign sel_a = op_sel[0];
  assign sel_b = op_sel[1];

endmodule

// File: rtl/hazard_ctrl.sv
module hazard_ctrl
  import hz_pkg::*;
#(
  parameter int unsigned REG_AW        = 5,
  parameter int unsigned PC_W          = 32,
  parameter bit          FWD_EN        = 1'b1,
  parameter bit          RESOLVE_IN_ID = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              id_valid,
  input  logic [REG_AW-1:0] id_rs1,
  input  logic              id_rs1_en,
  input  logic [REG_AW-1:0] id_rs2,
  input  logic              id_rs2_en,
  input  logic [REG_AW-1:0] id_rd,
  input  logic              id_wen,
  input  logic              id_load,
  input  logic              id_mem,
  input  logic              br_valid,
  input  logic              br_taken,
  input  logic [PC_W-1:0]   br_target,
  output logic              hold_pc,
  output logic              hold_id,
  output logic              bubble_id,
  output logic              bubble_ex,
  output logic [1:0]        fwd_a,
  output logic [1:0]        fwd_b,
  output logic              redirect,
  output logic [PC_W-1:0]   redirect_pc
);

  // Named internal events, also observed by the bound checker.
  logic              ex_vld, ex_wen, ex_load, ex_rs1_en, ex_rs2_en;
  logic [REG_AW-1:0] ex_rd, ex_rs1, ex_rs2;
  logic              ma_vld, ma_wen, ma_mem;
  logic [REG_AW-1:0] ma_rd;
  logic              wb_vld, wb_wen;
  logic [REG_AW-1:0] wb_rd;
  logic              load_use, raw_pending, data_stall;
  logic              struct_hit, taken_now;
  fwd_src_e          sel_a, sel_b;

  hz_track #(.RAW(REG_AW)) u_track (
    .clk       (clk),
    .rst_n     (rst_n),
    .id_valid  (id_valid),
    .id_rd     (id_rd),
    .id_rs1    (id_rs1),
    .id_rs1_en (id_rs1_en),
    .id_rs2    (id_rs2),
    .id_rs2_en (id_rs2_en),
    .id_wen    (id_wen),
    .id_load   (id_load),
    .id_mem    (id_mem),
    .kill_ex   (bubble_ex),
    .ex_vld    (ex_vld),
    .ex_wen    (ex_wen),
    .ex_rd     (ex_rd),
    .ex_load   (ex_load),
    .ex_rs1    (ex_rs1),
    .ex_rs1_en (ex_rs1_en),
    .ex_rs2    (ex_rs2),
    .ex_rs2_en (ex_rs2_en),
    .ma_vld    (ma_vld),
    .ma_wen    (ma_wen),
    .ma_rd     (ma_rd),
    .ma_mem    (ma_mem),
    .wb_vld    (wb_vld),
    .wb_wen    (wb_wen),
    .wb_rd     (wb_rd)
  );

  hz_dep #(.RAW(REG_AW), .FWD_EN(FWD_EN)) u_dep (
    .id_valid    (id_valid),
    .id_rs1      (id_rs1),
    .id_rs1_en   (id_rs1_en),
    .id_rs2      (id_rs2),
    .id_rs2_en   (id_rs2_en),
    .ex_vld      (ex_vld),
    .ex_wen      (ex_wen),
    .ex_rd       (ex_rd),
    .ex_load     (ex_load),
    .ma_vld      (ma_vld),
    .ma_wen      (ma_wen),
    .ma_rd       (ma_rd),
    .wb_vld      (wb_vld),
    .wb_wen      (wb_wen),
    .wb_rd       (wb_rd),
    .load_use    (load_use),
    .raw_pending (raw_pending),
    .data_stall  (data_stall)
  );

  hz_fwd #(.RAW(REG_AW), .FWD_EN(FWD_EN)) u_fwd (
    .ex_vld    (ex_vld),
    .ex_rs1    (ex_rs1),
    .ex_rs1_en (ex_rs1_en),
    .ex_rs2    (ex_rs2),
    .ex_rs2_en (ex_rs2_en),
    .ma_vld    (ma_vld),
    .ma_wen    (ma_wen),
    .ma_rd     (ma_rd),
    .wb_vld    (wb_vld),
    .wb_wen    (wb_wen),
    .wb_rd     (wb_rd),
    .sel_a     (sel_a),
    .sel_b     (sel_b)
  );

  // The memory stage owns the single port; fetch waits.
  assign struct_hit = ma_vld & ma_mem;
  assign taken_now  = br_valid & br_taken;

  // A taken branch outranks every stall.
  assign hold_id   = data_stall & ~taken_now;
  assign hold_pc   = (data_stall | struct_hit) & ~taken_now;
  assign bubble_id = taken_now | (struct_hit & ~data_stall);

  if (RESOLVE_IN_ID) begin : g_res_id
    assign bubble_ex = data_stall & ~taken_now;
  end else begin : g_res_ex
    assign bubble_ex = (data_stall & ~taken_now) | taken_now;
  end

  assign redirect    = taken_now;
  assign redirect_pc = br_target;
  assign fwd_a       = sel_a;
  assign fwd_b       = sel_b;

endmodule

// File: rtl/hz_chk.sv
module hz_chk #(
  parameter int unsigned RAW = 5
) (
  input logic           clk,
  input logic           rst_n,
  input logic           hold_pc,
  input logic           hold_id,
  input logic           bubble_id,
  input logic           bubble_ex,
  input logic           redirect,
  input logic [1:0]     fwd_a,
  input logic [1:0]     fwd_b,
  input logic           ex_vld,
  input logic [RAW-1:0] ex_rs1,
  input logic [RAW-1:0] ex_rs2,
  input logic           struct_hit
);

  AST_FETCH_YIELDS: assert property (@(posedge clk) disable iff (!rst_n)
    (struct_hit && !redirect) |-> hold_pc);  // R2

  AST_FETCH_SLOT_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    (struct_hit && !hold_id) |-> bubble_id);  // R2

  AST_SEL_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    (fwd_a != 2'd3) && (fwd_b != 2'd3));  // R3

  AST_ZERO_REG_A: assert property (@(posedge clk) disable iff (!rst_n)
    (fwd_a != 2'd0) |-> (ex_rs1 != '0));  // R4

  AST_ZERO_REG_B: assert property (@(posedge clk) disable iff (!rst_n)
    (fwd_b != 2'd0) |-> (ex_rs2 != '0));  // R4

  AST_STALL_SHAPE: assert property (@(posedge clk) disable iff (!rst_n)
    hold_id |-> (hold_pc && bubble_ex));  // R7

  AST_FLUSH_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    redirect |-> (!hold_pc && !hold_id));  // R10

  AST_SQUASH_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    bubble_ex |=> !ex_vld);  // R11

endmodule

bind hazard_ctrl hz_chk #(.RAW(REG_AW)) u_hz_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .hold_pc    (hold_pc),
  .hold_id    (hold_id),
  .bubble_id  (bubble_id),
  .bubble_ex  (bubble_ex),
  .redirect   (redirect),
  .fwd_a      (fwd_a),
  .fwd_b      (fwd_b),
  .ex_vld     (ex_vld),
  .ex_rs1     (ex_rs1),
  .ex_rs2     (ex_rs2),
  .struct_hit (struct_hit)
);

// File: tb/test_hazard_ctrl.sv
`timescale 1ns/1ps
module test_hazard_ctrl;

  typedef struct packed {
    logic       v;
    logic [4:0] rs1;
    logic       u1;
    logic [4:0] rs2;
    logic       u2;
    logic [4:0] rd;
    logic       w;
    logic       ld;
    logic       m;
  } ins_t;

  localparam ins_t NOP = '0;

  // ld, gap, producer rd, consumer reads via operand B, expected stalls
  // (bypass copy / no-bypass copy), expected select on the bypass copy.
  typedef struct packed {
    logic       ld;
    logic [1:0] gap;
    logic [4:0] rd;
    logic       use_b;
    logic [1:0] st_f;
    logic [1:0] st_n;
    logic [1:0] sel_f;
  } vec_t;

  localparam int NVEC = 9;
  localparam vec_t VEC [NVEC] = '{
    '{1'b0, 2'd0, 5'd5, 1'b0, 2'd0, 2'd3, 2'd1},
    '{1'b0, 2'd1, 5'd5, 1'b1, 2'd0, 2'd2, 2'd2},
    '{1'b0, 2'd2, 5'd5, 1'b0, 2'd0, 2'd1, 2'd0},
    '{1'b0, 2'd3, 5'd5, 1'b1, 2'd0, 2'd0, 2'd0},
    '{1'b1, 2'd0, 5'd6, 1'b0, 2'd1, 2'd3, 2'd2},
    '{1'b1, 2'd1, 5'd6, 1'b1, 2'd0, 2'd2, 2'd2},
    '{1'b1, 2'd2, 5'd6, 1'b0, 2'd0, 2'd0, 2'd0},
    '{1'b0, 2'd0, 5'd0, 1'b0, 2'd0, 2'd0, 2'd0},
    '{1'b1, 2'd0, 5'd0, 1'b1, 2'd0, 2'd0, 2'd0}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  ins_t ia = NOP, ib = NOP;
  logic br_v = 1'b0, br_t = 1'b0;
  logic [31:0] br_tg = '0;

  logic hp_a, hi_a, bi_a, be_a, rd_a;
  logic hp_b, hi_b, bi_b, be_b, rd_b;
  logic [1:0] fa_a, fb_a, fa_b, fb_b;
  logic [31:0] rpc_a, rpc_b;

  hazard_ctrl #(.FWD_EN(1'b1), .RESOLVE_IN_ID(1'b0)) i_hazard_ctrl (
    .clk(clk), .rst_n(rst_n), .id_valid(ia.v), .id_rs1(ia.rs1), .id_rs1_en(ia.u1),
    .id_rs2(ia.rs2), .id_rs2_en(ia.u2), .id_rd(ia.rd), .id_wen(ia.w), .id_load(ia.ld),
    .id_mem(ia.m), .br_valid(br_v), .br_taken(br_t), .br_target(br_tg),
    .hold_pc(hp_a), .hold_id(hi_a), .bubble_id(bi_a), .bubble_ex(be_a),
    .fwd_a(fa_a), .fwd_b(fb_a), .redirect(rd_a), .redirect_pc(rpc_a));

  hazard_ctrl #(.FWD_EN(1'b0), .RESOLVE_IN_ID(1'b1)) i_hazard_ctrl_nf (
    .clk(clk), .rst_n(rst_n), .id_valid(ib.v), .id_rs1(ib.rs1), .id_rs1_en(ib.u1),
    .id_rs2(ib.rs2), .id_rs2_en(ib.u2), .id_rd(ib.rd), .id_wen(ib.w), .id_load(ib.ld),
    .id_mem(ib.m), .br_valid(br_v), .br_taken(br_t), .br_target(br_tg),
    .hold_pc(hp_b), .hold_id(hi_b), .bubble_id(bi_b), .bubble_ex(be_b),
    .fwd_a(fa_b), .fwd_b(fb_b), .redirect(rd_b), .redirect_pc(rpc_b));

  int n_chk = 0;
  int n_err = 0;
  bit done = 0;

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    ia = NOP; ib = NOP;
    br_v = 1'b0; br_t = 1'b0;
    repeat (2) @(posedge clk);
    #1 rst_n = 1'b1;
  endtask

  function automatic ins_t mk(input logic [4:0] rs1, input logic u1,
                              input logic [4:0] rs2, input logic u2,
                              input logic [4:0] rd, input logic w,
                              input logic ld, input logic m);
    ins_t t;
    t = '{1'b1, rs1, u1, rs2, u2, rd, w, ld, m};
    return t;
  endfunction

  // Streams producer, gap no-ops, consumer through both copies; each copy
  // delivers its next instruction only when its decode register moves on.
  task automatic run_vec(input vec_t e, input int idx);
    ins_t s [6];
    int   n, cons, xa, xb, pa, pb, nxa, nxb, st_a, st_b;
    logic cap_a, cap_b;
    logic [1:0] sa, sb;
    ins_t na, nb;
    string tg4;
    for (int k = 0; k < 6; k++) s[k] = NOP;
    s[0] = mk(5'd0, 1'b0, 5'd0, 1'b0, e.rd, 1'b1, e.ld, e.ld);
    cons = int'(e.gap) + 1;
    n = cons + 1;
    s[cons] = mk(e.use_b ? 5'd0 : e.rd, !e.use_b, e.use_b ? e.rd : 5'd0, e.use_b,
                 5'd9, 1'b1, 1'b0, 1'b0);
    do_reset();
    ia = s[0]; ib = s[0];
    xa = 0; xb = 0; pa = 1; pb = 1; st_a = 0; st_b = 0;
    cap_a = 0; cap_b = 0; sa = 2'd3; sb = 2'd3;
    for (int c = 0; c < 14; c++) begin
      @(negedge clk);
      if (cap_a) begin sa = e.use_b ? fb_a : fa_a; cap_a = 0; end
      if (cap_b) begin sb = e.use_b ? fb_b : fa_b; cap_b = 0; end
      if (xa == cons && hi_a) st_a++;
      if (xb == cons && hi_b) st_b++;
      if (hi_a) begin na = ia; nxa = xa; end
      else begin
        if (xa == cons) cap_a = 1;
        if (bi_a) begin na = NOP; nxa = -1; end
        else if (pa < n) begin na = s[pa]; nxa = pa; pa++; end
        else begin na = NOP; nxa = -1; end
      end
      if (hi_b) begin nb = ib; nxb = xb; end
      else begin
        if (xb == cons) cap_b = 1;
        if (bi_b) begin nb = NOP; nxb = -1; end
        else if (pb < n) begin nb = s[pb]; nxb = pb; pb++; end
        else begin nb = NOP; nxb = -1; end
      end
      tick();
      ia = na; xa = nxa; ib = nb; xb = nxb;
    end
    tg4 = (e.rd == 5'd0) ? "R4" : "";
    chk($sformatf("R5 %s bypass stall row %0d", tg4, idx), st_a, int'(e.st_f));
    chk($sformatf("R6 %s no-bypass stall row %0d", tg4, idx), st_b, int'(e.st_n));
    chk($sformatf("R3 %s bypass select row %0d", tg4, idx), int'(sa), int'(e.sel_f));
    chk($sformatf("R6 no-bypass select row %0d", idx), int'(sb), 0);
  endtask

  initial begin
    // R1: reset state
    rst_n = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk("R1 hold_pc in reset", int'(hp_a | hp_b), 0);
    chk("R1 hold_id/bubbles in reset", int'(hi_a | bi_a | be_a | hi_b | bi_b | be_b), 0);
    chk("R1 selects/redirect in reset", int'(fa_a) + int'(fb_a) + int'(rd_a) + int'(rd_b), 0);
    do_reset();
    @(negedge clk);
    chk("R1 idle after release", int'(hp_a | hi_a | bi_a | be_a | rd_a | hp_b | rd_b), 0);

    // Dependence table (R3 R4 R5 R6)
    for (int v = 0; v < NVEC; v++) run_vec(VEC[v], v);

    // R8: not taken
    do_reset();
    br_v = 1'b1; br_t = 1'b0; br_tg = 32'h0000_0040;
    @(negedge clk);
    chk("R8 not taken redirect", int'(rd_a | rd_b), 0);
    chk("R8 not taken bubbles", int'(bi_a | be_a | bi_b | be_b), 0);

    // R9: taken, both resolution stages
    tick();
    br_t = 1'b1;
    @(negedge clk);
    chk("R9 redirect", int'(rd_a & rd_b), 1);
    chk("R9 target", int'(rpc_a == 32'h40 && rpc_b == 32'h40), 1);
    chk("R9 resolve in EX bubbles", int'({bi_a, be_a}), 3);
    chk("R9 resolve in ID bubbles", int'({bi_b, be_b}), 2);

    // R7 + R10 on the no-bypass copy: dependence stall meets a taken branch
    do_reset();
    ib = mk(5'd0, 1'b0, 5'd0, 1'b0, 5'd5, 1'b1, 1'b0, 1'b0);
    tick();
    ib = mk(5'd5, 1'b1, 5'd0, 1'b0, 5'd0, 1'b0, 1'b0, 1'b0);
    @(negedge clk);
    chk("R7 stall shape", int'({hp_b, hi_b, be_b}), 7);
    tick();
    br_v = 1'b1; br_t = 1'b1; br_tg = 32'h0000_0100;
    @(negedge clk);
    chk("R10 flush beats data stall", int'({hp_b, hi_b, rd_b}), 1);

    // R2: store in MA blocks fetch on the bypass copy
    do_reset();
    ia = mk(5'd1, 1'b1, 5'd2, 1'b1, 5'd0, 1'b0, 1'b0, 1'b1);
    tick();
    ia = NOP;
    tick();
    @(negedge clk);
    chk("R2 fetch port conflict", int'({hp_a, bi_a, hi_a}), 6);

    // R10: same conflict with a taken branch in EX
    do_reset();
    ia = mk(5'd1, 1'b1, 5'd2, 1'b1, 5'd0, 1'b0, 1'b0, 1'b1);
    tick();
    ia = NOP;
    tick();
    br_v = 1'b1; br_t = 1'b1; br_tg = 32'h0000_0200;
    @(negedge clk);
    chk("R10 flush beats fetch conflict", int'({hp_a, rd_a}), 1);

    // R11: a squashed load leaves no trace
    do_reset();
    ia = mk(5'd0, 1'b0, 5'd0, 1'b0, 5'd7, 1'b1, 1'b1, 1'b1);
    br_v = 1'b1; br_t = 1'b1; br_tg = 32'h0000_0300;
    tick();
    br_v = 1'b0; br_t = 1'b0;
    ia = mk(5'd7, 1'b1, 5'd0, 1'b0, 5'd8, 1'b1, 1'b0, 1'b0);
    @(negedge clk);
    chk("R11 no stall on squashed load", int'(hi_a), 0);
    tick();
    ia = NOP;
    @(negedge clk);
    chk("R11 no fetch conflict from squashed load", int'(hp_a), 0);
    chk("R11 consumer reads register file", int'(fa_a), 0);

    // R3: youngest producer wins
    do_reset();
    ia = mk(5'd0, 1'b0, 5'd0, 1'b0, 5'd5, 1'b1, 1'b0, 1'b0);
    tick();
    ia = mk(5'd0, 1'b0, 5'd0, 1'b0, 5'd5, 1'b1, 1'b0, 1'b0);
    tick();
    ia = mk(5'd5, 1'b1, 5'd5, 1'b1, 5'd9, 1'b1, 1'b0, 1'b0);
    @(negedge clk);
    chk("R5 no stall behind ALU producer", int'(hi_a), 0);
    tick();
    ia = NOP;
    @(negedge clk);
    chk("R3 youngest wins operand A", int'(fa_a), 1);
    chk("R3 youngest wins operand B", int'(fb_a), 1);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog R1 actual=running expected=finished");
      $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end

endmodule